// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block runs the start-up self-tests of a security module and keeps its data services shut until every scheduled test has passed. Once it leaves reset in the approved mode, it asks non-volatile storage for a persistent history bit. That bit records whether the complete test set passed on an earlier boot. A set bit selects a short plan with two tests: the image integrity test and the entropy-source bootstrap test. A clear bit selects the complete plan, which adds the algorithm tests.

Each test engine sits behind its own request/done/pass handshake. The integrity engine also presents a freshly computed keyed hash and the stored reference value, and the sequencer compares the two. Any failure, including a test that never answers, sends the sequencer to an error state. That state raises a reset request for a fixed number of cycles and then restarts the whole sequence. When the complete plan passes, the history bit is written to one. A boot in the non-approved mode writes it to zero, so the next approved boot runs the complete plan again.

Top module: `pst_sequencer`

## Requirements
- R1: While `rst` is high, every request output, `rst_req` and `svc_ready` are low and `status_state` is 0 (boot). In the approved mode the flag read request (`nv_rd_req`) comes before any test request.
- R2: If the flag read returns 1, only tests 0 and 1 are requested, in that order. `svc_ready` then rises with no storage write and stays high until reset.
- R3: If the flag read returns 0, tests 0 to 7 are requested in ascending order. `tst_req` is one-hot, with bit i requesting test i, and each request is held until that test's done.
- R4: Test 0 (integrity) passes only if `tst_pass[0]` is high and `mac_calc` equals `mac_ref` in its done cycle. Otherwise it fails.
- R5: After any failure, `rst_req` is high for exactly ERR_CYC cycles (default 4). The sequence then restarts in the boot state.
- R6: A test that gives no done within TMO_CYC cycles (default 16) of its request fails. Its request is held for exactly TMO_CYC cycles.
- R7: While `svc_ready` is low, `core_din_vld` and `svc_dout_vld` are low and `core_din` and `svc_dout` are zero. While it is high, both paths pass through unchanged.
- R8: After the complete plan passes, a storage write with value 1 is issued and `svc_ready` rises after `nv_wr_done`. A failing run issues no write.
- R9: A boot with `mode_approved` low issues no flag read and no test request. It writes value 0 to storage and then raises `svc_ready`.
- R10: `mode_approved` is sampled only in the boot state. A change later in the run has no effect.
- R11: Done or pass inputs of any test other than the one currently requested are ignored.
- R12: `status_state` encodes boot=0, read=1, run=2, write=3, ready=4 and error=5. `status_fail` holds the index of the last failing test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_approved | input | 1 | Approved mode selected for this boot |
| nv_rd_req | output | 1 | Request to read the history bit |
| nv_rd_done | input | 1 | Read complete |
| nv_rd_flag | input | 1 | History bit value returned with the read |
| nv_wr_req | output | 1 | Request to write the history bit |
| nv_wr_val | output | 1 | Value to write |
| nv_wr_done | input | 1 | Write complete |
| tst_req | output | NUM_TESTS | One-hot test start request |
| tst_done | input | NUM_TESTS | Per-test completion |
| tst_pass | input | NUM_TESTS | Per-test verdict, valid with done |
| mac_calc | input | MAC_W | Freshly computed keyed hash of the image |
| mac_ref | input | MAC_W | Stored reference hash |
| rst_req | output | 1 | Reset request from the error state |
| svc_ready | output | 1 | Services open |
| svc_din_vld | input | 1 | Caller data valid |
| svc_din | input | DATA_W | Caller data |
| core_din_vld | output | 1 | Gated data valid to the core |
| core_din | output | DATA_W | Gated data to the core |
| core_dout_vld | input | 1 | Core result valid |
| core_dout | input | DATA_W | Core result |
| svc_dout_vld | output | 1 | Gated result valid to the caller |
| svc_dout | output | DATA_W | Gated result to the caller |
| status_state | output | 3 | Sequencer state code |
| status_fail | output | $clog2(NUM_TESTS) | Index of the last failing test |

## Verification
The properties assume that storage completions arrive only while their own request is raised, and that `mode_approved` is changed only while the sequencer is at its boot sample or later in the run, never as a glitch between clock edges. The bench drives every input half a cycle away from the sampling edge. It raises `nv_rd_done` and `nv_wr_done` only in cycles where the matching request is seen. It deliberately pulses the done and pass lines of a test that is not the current one, which stresses the rule that only the current test's handshake counts.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,
        ST_READ  = 3'd1,
        ST_RUN   = 3'd2,
        ST_WRITE = 3'd3,
        ST_READY = 3'd4,
        ST_ERROR = 3'd5
    } seq_state_e;

    localparam int DEF_NUM_TESTS     = 8;
    localparam int DEF_REDUCED_TESTS = 2;
    localparam int DEF_TMO_CYC       = 16;
    localparam int DEF_ERR_CYC       = 4;
    localparam int DEF_MAC_W         = 32;
    localparam int DEF_DATA_W        = 32;
    localparam int INTEGRITY_IDX     = 0;

    typedef struct packed {
        logic hit;
        logic ok;
    } verdict_t;

endpackage

// File: rtl/pst_timer.sv
module pst_timer #(
    parameter int TMO_CYC = pst_pkg::DEF_TMO_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expired = run && (cnt == TW'(TMO_CYC - 1));
endmodule

// File: rtl/pst_verdict.sv
module pst_verdict #(
    parameter int NUM_TESTS = pst_pkg::DEF_NUM_TESTS,
    parameter int MAC_W     = pst_pkg::DEF_MAC_W
) (
    input  logic [NUM_TESTS-1:0]         tst_done,
    input  logic [NUM_TESTS-1:0]         tst_pass,
    input  logic [$clog2(NUM_TESTS)-1:0] idx,
    input  logic [MAC_W-1:0]             mac_calc,
    input  logic [MAC_W-1:0]             mac_ref,
    output pst_pkg::verdict_t            verdict
);
    logic [NUM_TESTS-1:0] pass_vec;
    logic                 mac_eq;

    assign mac_eq = (mac_calc == mac_ref);

    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_pass
        if (g == pst_pkg::INTEGRITY_IDX) begin : g_integ
            assign pass_vec[g] = tst_pass[g] & mac_eq;
        end else begin : g_plain
            assign pass_vec[g] = tst_pass[g];
        end
    end

    assign verdict.hit = tst_done[idx];
    assign verdict.ok  = pass_vec[idx];
endmodule

// File: rtl/pst_gate.sv
module pst_gate #(
    parameter int DATA_W = pst_pkg::DEF_DATA_W
) (
    input  logic              open,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    assign out_vld  = open & in_vld;
    assign out_data = open ? in_data : '0;
endmodule

// File: rtl/pst_sequencer.sv
module pst_sequencer
    import pst_pkg::*;
#(
    parameter int NUM_TESTS     = DEF_NUM_TESTS,
    parameter int REDUCED_TESTS = DEF_REDUCED_TESTS,
    parameter int TMO_CYC       = DEF_TMO_CYC,
    parameter int ERR_CYC       = DEF_ERR_CYC,
    parameter int MAC_W         = DEF_MAC_W,
    parameter int DATA_W        = DEF_DATA_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_approved,
    output logic                         nv_rd_req,
    input  logic                         nv_rd_done,
    input  logic                         nv_rd_flag,
    output logic                         nv_wr_req,
    output logic                         nv_wr_val,
    input  logic                         nv_wr_done,
    output logic [NUM_TESTS-1:0]         tst_req,
    input  logic [NUM_TESTS-1:0]         tst_done,
    input  logic [NUM_TESTS-1:0]         tst_pass,
    input  logic [MAC_W-1:0]             mac_calc,
    input  logic [MAC_W-1:0]             mac_ref,
    output logic                         rst_req,
    output logic                         svc_ready,
    input  logic                         svc_din_vld,
    input  logic [DATA_W-1:0]            svc_din,
    output logic                         core_din_vld,
    output logic [DATA_W-1:0]            core_din,
    input  logic                         core_dout_vld,
    input  logic [DATA_W-1:0]            core_dout,
    output logic                         svc_dout_vld,
    output logic [DATA_W-1:0]            svc_dout,
    output logic [2:0]                   status_state,
    output logic [$clog2(NUM_TESTS)-1:0] status_fail
);
    localparam int IW = $clog2(NUM_TESTS);
    localparam int EW = $clog2(ERR_CYC + 1);
    localparam logic [IW-1:0] LAST_FULL    = IW'(NUM_TESTS - 1);
    localparam logic [IW-1:0] LAST_REDUCED = IW'(REDUCED_TESTS - 1);

    seq_state_e    state;
    logic [IW-1:0] idx;
    logic [IW-1:0] fail_q;
    logic [EW-1:0] err_cnt;
    logic          plan_full;
    logic          wr_val_q;
    logic          tmo_hit;
    logic          in_run;
    logic [IW-1:0] last_idx;
    verdict_t      vd;

    assign in_run   = (state == ST_RUN);
    assign last_idx = plan_full ? LAST_FULL : LAST_REDUCED;

    pst_verdict #(
        .NUM_TESTS(NUM_TESTS),
        .MAC_W    (MAC_W)
    ) u_verdict (
        .tst_done(tst_done),
        .tst_pass(tst_pass),
        .idx     (idx),
        .mac_calc(mac_calc),
        .mac_ref (mac_ref),
        .verdict (vd)
    );

    pst_timer #(
        .TMO_CYC(TMO_CYC)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (!in_run || vd.hit),
        .run    (in_run),
        .expired(tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_BOOT;
            idx       <= '0;
            fail_q    <= '0;
            err_cnt   <= '0;
            plan_full <= 1'b1;
            wr_val_q  <= 1'b0;
        end else begin
            case (state)
                ST_BOOT: begin
                    err_cnt <= '0;
                    idx     <= '0;
                    if (mode_approved) begin
                        state <= ST_READ;
                    end else begin
                        wr_val_q <= 1'b0;
                        state    <= ST_WRITE;
                    end
                end
                ST_READ: begin
                    if (nv_rd_done) begin
                        plan_full <= !nv_rd_flag;
                        idx       <= '0;
                        state     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (vd.hit) begin
                        if (!vd.ok) begin
                            fail_q <= idx;
                            state  <= ST_ERROR;
                        end else if (idx == last_idx) begin
                            if (plan_full) begin
                                wr_val_q <= 1'b1;
                                state    <= ST_WRITE;
                            end else begin
                                state <= ST_READY;
                            end
                        end else begin
                            idx <= idx + IW'(1);
                        end
                    end else if (tmo_hit) begin
                        fail_q <= idx;
                        state  <= ST_ERROR;
                    end
                end
                ST_WRITE: begin
                    if (nv_wr_done) begin
                        state <= ST_READY;
                    end
                end
                ST_READY: state <= ST_READY;
                ST_ERROR: begin
                    if (err_cnt == EW'(ERR_CYC - 1)) begin
                        state <= ST_BOOT;
                    end else begin
                        err_cnt <= err_cnt + EW'(1);
                    end
                end
                default: state <= ST_BOOT;
            endcase
        end
    end

    assign nv_rd_req    = (state == ST_READ);
    assign nv_wr_req    = (state == ST_WRITE);
    assign nv_wr_val    = wr_val_q;
    assign tst_req      = in_run ? (NUM_TESTS'(1) << idx) : '0;
    assign rst_req      = (state == ST_ERROR);
    assign svc_ready    = (state == ST_READY);
    assign status_state = state;
    assign status_fail  = fail_q;

    pst_gate #(.DATA_W(DATA_W)) u_gate_in (
        .open    (svc_ready),
        .in_vld  (svc_din_vld),
        .in_data (svc_din),
        .out_vld (core_din_vld),
        .out_data(core_din)
    );

    pst_gate #(.DATA_W(DATA_W)) u_gate_out (
        .open    (svc_ready),
        .in_vld  (core_dout_vld),
        .in_data (core_dout),
        .out_vld (svc_dout_vld),
        .out_data(svc_dout)
    );
endmodule

// File: rtl/pst_sequencer_chk.sv
module pst_sequencer_chk #(
    parameter int NUM_TESTS = pst_pkg::DEF_NUM_TESTS,
    parameter int DATA_W    = pst_pkg::DEF_DATA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 nv_rd_req,
    input logic                 nv_wr_req,
    input logic [NUM_TESTS-1:0] tst_req,
    input logic                 rst_req,
    input logic                 svc_ready,
    input logic                 core_din_vld,
    input logic [DATA_W-1:0]    core_din,
    input logic                 svc_dout_vld,
    input logic [DATA_W-1:0]    svc_dout,
    input logic [2:0]           status_state
);
    p_gate_shut_r7: assert property (@(posedge clk) disable iff (rst)
        !svc_ready |-> (!core_din_vld && !svc_dout_vld && core_din == '0 && svc_dout == '0));

    p_single_req_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tst_req));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (!svc_ready && tst_req == '0 && !nv_wr_req));

    p_ready_hold_r2: assert property (@(posedge clk) disable iff (rst)
        svc_ready |=> svc_ready);

    p_write_alone_r8: assert property (@(posedge clk) disable iff (rst)
        nv_wr_req |-> (tst_req == '0 && !nv_rd_req && !svc_ready));

    p_first_after_read_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_req[0]) |-> $past(nv_rd_req));

    p_err_code_r12: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (status_state == 3'd5));
endmodule

bind pst_sequencer pst_sequencer_chk #(
    .NUM_TESTS(NUM_TESTS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nv_rd_req   (nv_rd_req),
    .nv_wr_req   (nv_wr_req),
    .tst_req     (tst_req),
    .rst_req     (rst_req),
    .svc_ready   (svc_ready),
    .core_din_vld(core_din_vld),
    .core_din    (core_din),
    .svc_dout_vld(svc_dout_vld),
    .svc_dout    (svc_dout),
    .status_state(status_state)
);

// File: tb/pst_sequencer_tb_top.sv
module pst_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT   = 8;
    localparam int TMO  = 16;
    localparam int ERRC = 4;
    localparam int MW   = 32;
    localparam int DW   = 32;
    localparam int IW   = 3;
    localparam int NVEC = 10;

    typedef struct packed {
        logic       appr;
        logic       tog;
        logic       flag;
        logic [3:0] bad;
        logic [1:0] kind;     // 0 ok, 1 pass low, 2 no done, 3 hash mismatch
        logic [3:0] ntests;
        logic       exp_rd;
        logic [1:0] exp_wr;   // 0 none, 2 write 0, 3 write 1
        logic       exp_rdy;
        logic [2:0] exp_fail;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 1'b1, 4'd15, 2'd0, 4'd2, 1'b1, 2'd0, 1'b1, 3'd0},
        '{1'b1, 1'b0, 1'b0, 4'd15, 2'd0, 4'd8, 1'b1, 2'd3, 1'b1, 3'd0},
        '{1'b1, 1'b0, 1'b0, 4'd3,  2'd1, 4'd4, 1'b1, 2'd0, 1'b0, 3'd3},
        '{1'b1, 1'b0, 1'b1, 4'd1,  2'd1, 4'd2, 1'b1, 2'd0, 1'b0, 3'd1},
        '{1'b1, 1'b0, 1'b0, 4'd0,  2'd3, 4'd1, 1'b1, 2'd0, 1'b0, 3'd0},
        '{1'b1, 1'b0, 1'b0, 4'd0,  2'd1, 4'd1, 1'b1, 2'd0, 1'b0, 3'd0},
        '{1'b1, 1'b0, 1'b0, 4'd5,  2'd2, 4'd6, 1'b1, 2'd0, 1'b0, 3'd5},
        '{1'b1, 1'b0, 1'b1, 4'd7,  2'd1, 4'd2, 1'b1, 2'd0, 1'b1, 3'd0},
        '{1'b1, 1'b0, 1'b0, 4'd7,  2'd2, 4'd8, 1'b1, 2'd0, 1'b0, 3'd7},
        '{1'b0, 1'b0, 1'b1, 4'd15, 2'd0, 4'd0, 1'b0, 2'd2, 1'b1, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_approved = 1'b1;
    logic          nv_rd_req, nv_rd_done = 1'b0, nv_rd_flag = 1'b0;
    logic          nv_wr_req, nv_wr_val, nv_wr_done = 1'b0;
    logic [NT-1:0] tst_req, tst_done = '0, tst_pass = '1;
    logic [MW-1:0] mac_calc = 32'h1234_5678;
    logic [MW-1:0] mac_ref  = 32'h1234_5678;
    logic          rst_req, svc_ready;
    logic          svc_din_vld = 1'b1;
    logic [DW-1:0] svc_din = 32'hA5A5_0F0F;
    logic          core_din_vld;
    logic [DW-1:0] core_din;
    logic          core_dout_vld = 1'b1;
    logic [DW-1:0] core_dout = 32'h5A5A_F0F0;
    logic          svc_dout_vld;
    logic [DW-1:0] svc_dout;
    logic [2:0]    status_state;
    logic [IW-1:0] status_fail;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pst_sequencer #(
        .NUM_TESTS(NT), .REDUCED_TESTS(2), .TMO_CYC(TMO), .ERR_CYC(ERRC),
        .MAC_W(MW), .DATA_W(DW)
    ) dut_i (
        .clk(clk), .rst(rst), .mode_approved(mode_approved),
        .nv_rd_req(nv_rd_req), .nv_rd_done(nv_rd_done), .nv_rd_flag(nv_rd_flag),
        .nv_wr_req(nv_wr_req), .nv_wr_val(nv_wr_val), .nv_wr_done(nv_wr_done),
        .tst_req(tst_req), .tst_done(tst_done), .tst_pass(tst_pass),
        .mac_calc(mac_calc), .mac_ref(mac_ref),
        .rst_req(rst_req), .svc_ready(svc_ready),
        .svc_din_vld(svc_din_vld), .svc_din(svc_din),
        .core_din_vld(core_din_vld), .core_din(core_din),
        .core_dout_vld(core_dout_vld), .core_dout(core_dout),
        .svc_dout_vld(svc_dout_vld), .svc_dout(svc_dout),
        .status_state(status_state), .status_fail(status_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1;
        mode_approved = mode;
        tst_done = '0;
        nv_rd_done = 1'b0;
        nv_wr_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input int n, input vec_t v);
        int     seen = 0, order_err = 0, held = 0, held_bad = 0, rst_cyc = 0;
        bit     saw_rd = 0, saw_wr = 0, wr_val = 0, got_rdy = 0, got_err = 0;
        bit     stop = 0, gate_err = 0;
        int     fail_seen = 0, state_seen = 0, boot_state = 9;
        logic [NT-1:0] prev = '0;
        do_reset(v.appr);
        for (int it = 0; it < 400 && !stop; it++) begin
            @(negedge clk);
            tst_done   = '0;
            tst_pass   = '1;
            nv_rd_done = 1'b0;
            nv_wr_done = 1'b0;
            mac_calc   = mac_ref;
            if (!svc_ready && (core_din_vld || svc_dout_vld || core_din != '0 || svc_dout != '0))
                gate_err = 1;
            if (nv_rd_req) begin
                saw_rd     = 1;
                nv_rd_done = 1'b1;
                nv_rd_flag = v.flag;
                if (v.tog) mode_approved = ~mode_approved;
            end
            if (tst_req != '0) begin
                int i = 0;
                for (int k = 0; k < NT; k++) if (tst_req[k]) i = k;
                if (tst_req != prev) begin
                    if (i != seen || !saw_rd) order_err++;
                    seen++;
                    held = 0;
                end
                held++;
                if (i == int'(v.bad)) held_bad = held;
                // distractor handshake on a test that is not current (R11)
                tst_done[(i + 3) % NT] = 1'b1;
                tst_pass[(i + 3) % NT] = 1'b0;
                if (!(i == int'(v.bad) && v.kind == 2'd2)) begin
                    tst_done[i] = 1'b1;
                    tst_pass[i] = !(i == int'(v.bad) && v.kind == 2'd1);
                    if (i == int'(v.bad) && v.kind == 2'd3) mac_calc = mac_ref ^ 32'h1;
                end
            end
            prev = tst_req;
            if (nv_wr_req) begin
                saw_wr     = 1;
                wr_val     = nv_wr_val;
                nv_wr_done = 1'b1;
            end
            if (svc_ready) begin
                got_rdy = 1;
                stop    = 1;
                chk(core_din == svc_din && core_din_vld, "R7 open input path", int'(core_din_vld), 1);
                chk(svc_dout == core_dout && svc_dout_vld, "R7 open output path", int'(svc_dout_vld), 1);
            end else if (rst_req) begin
                got_err    = 1;
                rst_cyc++;
                fail_seen  = int'(status_fail);
                state_seen = int'(status_state);
            end else if (got_err) begin
                boot_state = int'(status_state);
                stop       = 1;
            end
        end
        chk(seen == int'(v.ntests), $sformatf("R3 R11 tests requested vec %0d", n), seen, int'(v.ntests));
        chk(order_err == 0, $sformatf("R1 R3 request order vec %0d", n), order_err, 0);
        chk(saw_rd == v.exp_rd, $sformatf("R1 R9 flag read vec %0d", n), int'(saw_rd), int'(v.exp_rd));
        chk({saw_wr, wr_val} == v.exp_wr, $sformatf("R8 R9 write vec %0d", n),
            int'({saw_wr, wr_val}), int'(v.exp_wr));
        chk(got_rdy == v.exp_rdy, $sformatf("R2 R4 R10 ready vec %0d", n), int'(got_rdy), int'(v.exp_rdy));
        chk(gate_err == 0, $sformatf("R7 gate shut vec %0d", n), int'(gate_err), 0);
        if (!v.exp_rdy) begin
            chk(got_err, $sformatf("R5 error reached vec %0d", n), int'(got_err), 1);
            chk(fail_seen == int'(v.exp_fail), $sformatf("R12 fail index vec %0d", n),
                fail_seen, int'(v.exp_fail));
            chk(state_seen == 5, $sformatf("R12 error code vec %0d", n), state_seen, 5);
            chk(rst_cyc == ERRC, $sformatf("R5 reset request length vec %0d", n), rst_cyc, ERRC);
            chk(boot_state == 0, $sformatf("R5 restart in boot vec %0d", n), boot_state, 0);
            if (v.kind == 2'd2)
                chk(held_bad == TMO, $sformatf("R6 timeout window vec %0d", n), held_bad, TMO);
            if (v.bad == 4'd0)
                chk(fail_seen == 0, $sformatf("R4 integrity failure vec %0d", n), fail_seen, 0);
        end
    endtask

    initial begin
        // reset state (R1, R12)
        repeat (2) @(negedge clk);
        chk(!nv_rd_req && !nv_wr_req && tst_req == '0, "R1 requests low in reset", int'(tst_req), 0);
        chk(!rst_req && !svc_ready, "R1 ready and reset request low", int'(svc_ready), 0);
        chk(status_state == 3'd0, "R12 boot code in reset", int'(status_state), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(nv_rd_req && tst_req == '0, "R1 read first after reset", int'(nv_rd_req), 1);
        chk(status_state == 3'd1, "R12 read code", int'(status_state), 1);

        for (int n = 0; n < NVEC; n++) run_vec(n, VEC[n]);

        // ready persists after the reduced plan (R2)
        run_vec(0, VEC[0]);
        repeat (20) @(negedge clk);
        chk(svc_ready && tst_req == '0, "R2 ready holds", int'(svc_ready), 1);
        chk(status_state == 3'd4, "R12 ready code", int'(status_state), 4);

        // mode change in the middle of a complete plan is ignored (R10)
        do_reset(1'b1);
        repeat (4) @(negedge clk);
        mode_approved = 1'b0;
        chk(status_state == 3'd2 || status_state == 3'd1, "R10 still approved flow",
            int'(status_state), 2);
        finish_run();
    end
endmodule